// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This controller takes single-bit read and write requests from a processor-side port and serves them from a square array of dynamic cells. Each request address is split into a row half and a column half. Both halves travel over one shared address bus, row first, then column. A row access copies the whole row into a row buffer. Reading a row destroys its contents in the array, so every access ends with a write-back of the whole buffer to the same row.

After an access the buffered row stays open. A later access to the same row starts directly with its column phase, with no row phase (page mode).

A refresh scheduler issues one refresh request every `RETENTION_CYC / ROWS` cycles and steps a row pointer through all rows in ascending order. A refresh cycle opens that row and writes it back, with no column phase, and it closes the open page. A pending refresh waits while the processor keeps requesting, but only until its slack counter reaches zero. It never interrupts an access already in flight.

Top module: `dram_ctrl`

The controller's states are:
- `ST_IDLE`: waiting, and choosing between the processor and refresh.
- `ST_ROW`: row phase of a processor access.
- `ST_COL`: column phase.
- `ST_WB`: write-back.
- `ST_RROW`: row phase of a refresh.
- `ST_RWB`: write-back of a refresh.

The transitions are:
- `ST_IDLE→ST_RROW`: refresh granted.
- `ST_IDLE→ST_ROW`: accept on a page miss.
- `ST_IDLE→ST_COL`: accept on a page hit.
- `ST_ROW→ST_COL`, `ST_COL→ST_WB` and `ST_WB→ST_IDLE`: each at the end of its phase.
- `ST_RROW→ST_RWB` and `ST_RWB→ST_IDLE`: each at the end of its phase.

## Requirements
- R1: After reset the controller is idle: `req_ready` is 1 when no refresh is due, `rsp_valid` and all array strobes are 0, and no page is open.
- R2: `req_addr[2*HALF_W-1:HALF_W]` is the row and `req_addr[HALF_W-1:0]` is the column. `arr_addr` carries the row during row and write-back phases and the column during the column phase.
- R3: A read that misses the open page has three phases. The row phase lasts `T_ROW` cycles, with `arr_sense` high in its last cycle. The column phase lasts `T_COL` cycles and the write-back `T_WB` cycles. `rsp_valid` is a one-cycle pulse `T_ROW+T_COL` clock edges after the accepting edge. Writes give no pulse.
- R4: Every row open ends with a write-back of the full row buffer, including a written bit, to the row that was opened. Data therefore survives the destructive sense.
- R5: An access whose row equals the open page skips the row phase. A read then responds `T_COL` edges after acceptance.
- R6: `req_ready` is high only in `ST_IDLE` when no refresh is being granted. The controller stays busy for `T_ROW+T_COL+T_WB` cycles on a miss and `T_COL+T_WB` cycles on a hit.
- R7: A refresh request is raised every `RETENTION_CYC/ROWS` cycles. Refreshed rows follow 0,1,…,ROWS-1 and then wrap. With no processor traffic, the refresh row phase starts on the cycle after the request.
- R8: A refresh cycle is `T_ROW` row cycles (sense in the last) followed by `T_WB` write-back cycles, with no column phase. The next processor access is a page miss.
- R9: While slack remains and `req_valid` is high, the processor is served first. Once slack reaches zero, the refresh wins in `ST_IDLE`. A refresh starts at most `REF_SLACK+T_ROW+T_COL+T_WB` cycles after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HALF_W | Row half (upper) and column half (lower) |
| req_wdata | input | 1 | Write bit |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 1 | Read bit |
| arr_addr | output | HALF_W | Multiplexed row/column address |
| arr_row_phase | output | 1 | Row phase in progress |
| arr_sense | output | 1 | Last row cycle: array delivers and clears the row |
| arr_col_phase | output | 1 | Column phase in progress |
| arr_wb | output | 1 | Write-back phase: row buffer to row `arr_addr` |
| arr_rdata | input | ROWS | Row contents from the array |
| arr_wdata | output | ROWS | Row buffer contents to the array |

## Verification
The bench counts clock edges from the accepting edge. It expects the read strobe after `T_ROW+T_COL` edges on a miss and `T_COL` on a hit, and it expects the controller back in idle `T_WB` edges later. All of this is sampled on falling edges, so each count is exact.

For refresh, a row is taken to have been refreshed when a write-back follows a sense with no column phase in between. The bench computes each refresh request edge as a multiple of the interval counted from reset release. It expects the write-back `1+T_ROW` edges after that request when idle, and within the slack-plus-one-access bound under traffic.

Data integrity is checked by exhaustive write and read sweeps over all addresses in row-major and column-major order against a destructive-read array model.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_WB,
        ST_RROW,
        ST_RWB
    } dstate_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned HALF_W       = 3,
    parameter int unsigned REF_INTERVAL = 40,
    parameter int unsigned REF_SLACK    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_take,
    input  logic              ref_done,
    output logic              ref_pending,
    output logic              ref_urgent,
    output logic [HALF_W-1:0] ref_row
);
    localparam int unsigned TMR_W = $clog2(REF_INTERVAL + 1);
    localparam int unsigned SLK_W = $clog2(REF_SLACK + 1) + 1;

    logic [TMR_W-1:0] tmr;
    logic [SLK_W-1:0] slack;
    logic             expire;

    assign expire     = (tmr == TMR_W'(REF_INTERVAL - 1));
    assign ref_urgent = (slack == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (expire) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_pending <= 1'b0;
            slack       <= SLK_W'(REF_SLACK);
        end else if (expire) begin
            ref_pending <= 1'b1;
            slack       <= SLK_W'(REF_SLACK);
        end else if (ref_take) begin
            ref_pending <= 1'b0;
        end else if (ref_pending && slack != '0) begin
            slack <= slack - SLK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_row <= '0;
        end else if (ref_done) begin
            ref_row <= ref_row + HALF_W'(1);
        end
    end

    // R7: a new request never lands on one still waiting
    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !ref_pending);

    // R7: the row pointer advances by one after each refresh
    assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> ref_row == HALF_W'($past(ref_row) + HALF_W'(1)));

    // R9: a grant only happens for a pending request
    assert_take_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_take |-> ref_pending);

endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
    parameter int unsigned HALF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [(1<<HALF_W)-1:0] load_data,
    input  logic [HALF_W-1:0] col,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic [(1<<HALF_W)-1:0] rbuf,
    output logic              rd_bit
);
    localparam int unsigned COLS = 1 << HALF_W;

    for (genvar g = 0; g < COLS; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rbuf[g] <= 1'b0;
            end else if (load) begin
                rbuf[g] <= load_data[g];
            end else if (wr_en && col == HALF_W'(g)) begin
                rbuf[g] <= wr_bit;
            end
        end
    end

    assign rd_bit = rbuf[col];

    // R4: a row capture and a column write never coincide
    assert_no_load_write_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !wr_en);

endmodule

// File: rtl/dram_ctrl_fsm.sv
module dram_ctrl_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned HALF_W = 3,
    parameter int unsigned T_ROW  = 3,
    parameter int unsigned T_COL  = 1,
    parameter int unsigned T_WB   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [2*HALF_W-1:0] req_addr,
    input  logic                req_wdata,
    output logic                rsp_valid,
    output logic                rsp_data,
    input  logic                ref_pending,
    input  logic                ref_urgent,
    input  logic [HALF_W-1:0]   ref_row,
    output logic                ref_take,
    output logic                ref_done,
    output logic                buf_load,
    output logic [HALF_W-1:0]   buf_col,
    output logic                buf_wr_en,
    output logic                buf_wr_bit,
    input  logic                buf_rd_bit,
    output logic [HALF_W-1:0]   arr_addr,
    output logic                arr_row_phase,
    output logic                arr_sense,
    output logic                arr_col_phase,
    output logic                arr_wb
);
    localparam int unsigned PH_MAX = max3(T_ROW, T_COL, T_WB);
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);

    dstate_t           state, state_nx;
    logic [PH_W-1:0]   ph, ph_len;
    logic              ph_last;
    logic [HALF_W-1:0] q_row, q_col, page_row;
    logic              q_we, q_wd, page_valid;
    logic              take_ref, accept, hit;
    logic [HALF_W-1:0] req_row, req_col;

    assign req_row = req_addr[2*HALF_W-1:HALF_W];
    assign req_col = req_addr[HALF_W-1:0];

    // phase length and end of phase
    always_comb begin
        unique case (state)
            ST_ROW, ST_RROW: ph_len = PH_W'(T_ROW);
            ST_COL:          ph_len = PH_W'(T_COL);
            ST_WB, ST_RWB:   ph_len = PH_W'(T_WB);
            default:         ph_len = PH_W'(1);
        endcase
        ph_last = ((ph + PH_W'(1)) == ph_len);
    end

    // arbitration in idle
    assign take_ref  = (state == ST_IDLE) && ref_pending && (ref_urgent || !req_valid);
    assign req_ready = (state == ST_IDLE) && !take_ref;
    assign accept    = req_valid && req_ready;
    assign hit       = page_valid && (page_row == req_row);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_ref)    state_nx = ST_RROW;
                else if (accept) state_nx = hit ? ST_COL : ST_ROW;
            end
            ST_ROW:  if (ph_last) state_nx = ST_COL;
            ST_COL:  if (ph_last) state_nx = ST_WB;
            ST_WB:   if (ph_last) state_nx = ST_IDLE;
            ST_RROW: if (ph_last) state_nx = ST_RWB;
            ST_RWB:  if (ph_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state || state == ST_IDLE) ph <= '0;
            else                                       ph <= ph + PH_W'(1);
        end
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_row <= '0;
            q_col <= '0;
            q_we  <= 1'b0;
            q_wd  <= 1'b0;
        end else if (accept) begin
            q_row <= req_row;
            q_col <= req_col;
            q_we  <= req_we;
            q_wd  <= req_wdata;
        end
    end

    // open page tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_valid <= 1'b0;
            page_row   <= '0;
        end else if (take_ref || (accept && !hit)) begin
            page_valid <= 1'b0;
        end else if (state == ST_WB && ph_last) begin
            page_valid <= 1'b1;
            page_row   <= q_row;
        end
    end

    // read response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_COL) && ph_last && !q_we;
            rsp_data  <= buf_rd_bit;
        end
    end

    // array and buffer controls
    always_comb begin
        arr_addr      = '0;
        arr_row_phase = 1'b0;
        arr_sense     = 1'b0;
        arr_col_phase = 1'b0;
        arr_wb        = 1'b0;
        ref_done      = 1'b0;
        unique case (state)
            ST_ROW: begin
                arr_addr      = q_row;
                arr_row_phase = 1'b1;
                arr_sense     = ph_last;
            end
            ST_COL: begin
                arr_addr      = q_col;
                arr_col_phase = 1'b1;
            end
            ST_WB: begin
                arr_addr = q_row;
                arr_wb   = 1'b1;
            end
            ST_RROW: begin
                arr_addr      = ref_row;
                arr_row_phase = 1'b1;
                arr_sense     = ph_last;
            end
            ST_RWB: begin
                arr_addr = ref_row;
                arr_wb   = 1'b1;
                ref_done = ph_last;
            end
            default: ;
        endcase
    end

    assign ref_take   = take_ref;
    assign buf_load   = arr_sense;
    assign buf_col    = q_col;
    assign buf_wr_en  = (state == ST_COL) && ph_last && q_we;
    assign buf_wr_bit = q_wd;

    // R3: the read strobe lasts one cycle
    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: a sense is always followed by a column phase or a write-back
    assert_sense_then_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_sense |=> (arr_col_phase || arr_wb));

    // R5: a page hit goes straight to the column phase
    assert_hit_skips_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (arr_col_phase && !arr_row_phase));

    // R6: ready only while the array is quiet
    assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(arr_row_phase || arr_col_phase || arr_wb));

    // R8: a refresh grant opens the scheduler's row
    assert_refresh_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_take |=> (arr_row_phase && arr_addr == $past(ref_row)));

    // R9: an urgent refresh blocks the processor
    assert_urgent_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pending && ref_urgent) |-> !req_ready);

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
    parameter int unsigned HALF_W        = 3,
    parameter int unsigned T_ROW         = 3,
    parameter int unsigned T_COL         = 1,
    parameter int unsigned T_WB          = 2,
    parameter int unsigned RETENTION_CYC = 320,
    parameter int unsigned REF_SLACK     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [2*HALF_W-1:0]      req_addr,
    input  logic                     req_wdata,
    output logic                     rsp_valid,
    output logic                     rsp_data,
    output logic [HALF_W-1:0]        arr_addr,
    output logic                     arr_row_phase,
    output logic                     arr_sense,
    output logic                     arr_col_phase,
    output logic                     arr_wb,
    input  logic [(1<<HALF_W)-1:0]   arr_rdata,
    output logic [(1<<HALF_W)-1:0]   arr_wdata
);
    localparam int unsigned ROWS         = 1 << HALF_W;
    localparam int unsigned REF_INTERVAL = RETENTION_CYC / ROWS;

    logic              ref_pending, ref_urgent, ref_take, ref_done;
    logic [HALF_W-1:0] ref_row, buf_col;
    logic              buf_load, buf_wr_en, buf_wr_bit, buf_rd_bit;
    logic [ROWS-1:0]   rbuf;

    dram_refresh_sched #(
        .HALF_W      (HALF_W),
        .REF_INTERVAL(REF_INTERVAL),
        .REF_SLACK   (REF_SLACK)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_take   (ref_take),
        .ref_done   (ref_done),
        .ref_pending(ref_pending),
        .ref_urgent (ref_urgent),
        .ref_row    (ref_row)
    );

    dram_row_buffer #(
        .HALF_W(HALF_W)
    ) u_rbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (buf_load),
        .load_data(arr_rdata),
        .col      (buf_col),
        .wr_en    (buf_wr_en),
        .wr_bit   (buf_wr_bit),
        .rbuf     (rbuf),
        .rd_bit   (buf_rd_bit)
    );

    dram_ctrl_fsm #(
        .HALF_W(HALF_W),
        .T_ROW (T_ROW),
        .T_COL (T_COL),
        .T_WB  (T_WB)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .ref_pending  (ref_pending),
        .ref_urgent   (ref_urgent),
        .ref_row      (ref_row),
        .ref_take     (ref_take),
        .ref_done     (ref_done),
        .buf_load     (buf_load),
        .buf_col      (buf_col),
        .buf_wr_en    (buf_wr_en),
        .buf_wr_bit   (buf_wr_bit),
        .buf_rd_bit   (buf_rd_bit),
        .arr_addr     (arr_addr),
        .arr_row_phase(arr_row_phase),
        .arr_sense    (arr_sense),
        .arr_col_phase(arr_col_phase),
        .arr_wb       (arr_wb)
    );

    assign arr_wdata = rbuf;

endmodule

// File: tb/dram_ctrl_bench.sv
`timescale 1ns/1ps
module dram_ctrl_bench;
    localparam int H = 3, ROWS = 8, NADDR = 64;
    localparam int T_ROW = 3, T_COL = 1, T_WB = 2, RET = 320, SLACK = 8;
    localparam int IVL = RET / ROWS;
    localparam int TACC = T_ROW + T_COL + T_WB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
    logic [2*H-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_data;
    logic [H-1:0] arr_addr;
    logic arr_row_phase, arr_sense, arr_col_phase, arr_wb;
    logic [ROWS-1:0] arr_rdata, arr_wdata;

    always #2.5 clk = ~clk;

    dram_ctrl #(.HALF_W(H), .T_ROW(T_ROW), .T_COL(T_COL), .T_WB(T_WB),
                .RETENTION_CYC(RET), .REF_SLACK(SLACK)) u_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .arr_addr(arr_addr),
        .arr_row_phase(arr_row_phase), .arr_sense(arr_sense),
        .arr_col_phase(arr_col_phase), .arr_wb(arr_wb),
        .arr_rdata(arr_rdata), .arr_wdata(arr_wdata));

    // destructive-read array model
    logic [ROWS-1:0] mem [ROWS];
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
        end else if (arr_sense) begin
            mem[arr_addr] <= '0;
        end else if (arr_wb) begin
            mem[arr_addr] <= arr_wdata;
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bench models
    bit shadow [NADDR];
    bit page_m_valid = 1'b0;
    int page_m_row = 0;
    bit cpu_active = 1'b0;
    int cur_row = 0, cur_col = 0;
    int ref_count = 0, exp_ref_row = 0;
    bit strict = 1'b0;
    bit seen_col = 1'b0, prev_wb = 1'b0, prev_col = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_sense) begin
                seen_col = 1'b0;
                if (cpu_active) chk(int'(arr_addr) == cur_row, "R2 row half", arr_addr, cur_row);
            end
            if (arr_col_phase && !prev_col)
                chk(cpu_active && int'(arr_addr) == cur_col, "R2 column half", arr_addr, cur_col);
            if (arr_col_phase) seen_col = 1'b1;
            if (arr_wb && !prev_wb && !seen_col) begin
                int d;
                ref_count++;
                chk(int'(arr_addr) == exp_ref_row, "R7 refresh order", arr_addr, exp_ref_row);
                exp_ref_row = (exp_ref_row + 1) % ROWS;
                chk(!cpu_active, "R8 refresh during access", cpu_active, 0);
                d = cyc - T_ROW - 1 - ref_count * IVL;
                chk(d >= 0 && d <= SLACK + TACC, "R9 refresh delay bound", d, SLACK + TACC);
                if (strict) chk(d == 0, "R7 idle refresh timing", d, 0);
                page_m_valid = 1'b0;
            end
            prev_wb  = arr_wb;
            prev_col = arr_col_phase;
        end
    end

    function automatic bit pat(input int a, input int v);
        return bit'((a ^ (a >> 2) ^ (a >> 4) ^ v) & 1);
    endfunction

    int last_lat = 0;
    task automatic access(input bit we, input int a, input bit wd);
        int lat, busy, tries;
        bit exp_hit, rd;
        cur_row = a / ROWS;
        cur_col = a % ROWS;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = (2*H)'(a); req_wdata = wd;
        #1;
        tries = 0;
        while (!req_ready && tries < 1000) begin
            @(negedge clk); #1; tries++;
        end
        @(posedge clk);
        exp_hit = page_m_valid && page_m_row == cur_row;
        @(negedge clk);
        req_valid = 1'b0;
        cpu_active = 1'b1;
        busy = exp_hit ? T_COL + T_WB : TACC;
        lat = 0;
        if (!we) begin
            while (!rsp_valid && lat < 32) begin
                @(negedge clk); lat++;
            end
            last_lat = lat;
            rd = rsp_data;
            chk(lat == (exp_hit ? T_COL : T_ROW + T_COL), exp_hit ? "R5 hit latency" : "R3 miss latency",
                lat, exp_hit ? T_COL : T_ROW + T_COL);
            chk(rd == shadow[a], "R4 read data", rd, shadow[a]);
            chk(req_ready == 1'b0, "R6 busy", req_ready, 0);
            @(negedge clk); lat++;
            chk(rsp_valid == 1'b0, "R3 single pulse", rsp_valid, 0);
        end else begin
            shadow[a] = wd;
        end
        while (lat < busy) begin
            @(negedge clk); lat++;
            if (we && rsp_valid) chk(1'b0, "R3 write strobe", 1, 0);
        end
        cpu_active = 1'b0;
        page_m_valid = 1'b1;
        page_m_row = cur_row;
    endtask

    bit done = 1'b0;
    initial begin
        for (int i = 0; i < NADDR; i++) shadow[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
        chk({arr_row_phase, arr_sense, arr_col_phase, arr_wb} == 4'b0, "R1 strobes quiet",
            {arr_row_phase, arr_sense, arr_col_phase, arr_wb}, 0);
        // R1: first access is a miss (page closed)
        access(1'b0, 0, 1'b0);
        chk(last_lat == T_ROW + T_COL, "R1 closed page", last_lat, T_ROW + T_COL);
        // R4 R5: row-major writes then reads
        for (int a = 0; a < NADDR; a++) access(1'b1, a, pat(a, 0));
        for (int a = 0; a < NADDR; a++) access(1'b0, a, 1'b0);
        // R3 R2: column-major writes and reads, all misses
        for (int c = 0; c < ROWS; c++)
            for (int r = 0; r < ROWS; r++) access(1'b1, r * ROWS + c, pat(r * ROWS + c, 1));
        for (int c = 0; c < ROWS; c++)
            for (int r = 0; r < ROWS; r++) access(1'b0, r * ROWS + c, 1'b0);
        // R7: idle window with exact timing
        repeat (IVL + SLACK + TACC + 4) @(negedge clk);
        strict = 1'b1;
        repeat (3 * IVL) @(negedge clk);
        strict = 1'b0;
        // R8: a refresh closes the page
        begin
            int rc;
            access(1'b0, 18, 1'b0);
            access(1'b0, 19, 1'b0);
            chk(last_lat == T_COL, "R5 hit before refresh", last_lat, T_COL);
            rc = ref_count;
            while (ref_count == rc) @(negedge clk);
            repeat (T_WB + 1) @(negedge clk);
            access(1'b0, 20, 1'b0);
            chk(last_lat == T_ROW + T_COL, "R8 page closed by refresh", last_lat, T_ROW + T_COL);
        end
        // R9: sustained hits, refresh must still get through
        for (int k = 0; k < 200; k++) access(1'b0, 40 + (k % 8), 1'b0);
        for (int a = 0; a < NADDR; a++) access(1'b0, a, 1'b0);
        chk(ref_count >= cyc / IVL - 1, "R7 refresh count", ref_count, cyc / IVL - 1);
        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 200000) begin
            @(posedge clk); n++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", n, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule